// File: doc/BRIEF.md
# Watchdog Timer with Timed Disable Window

The block is a watchdog timer that runs from its own free-running oscillator clock, separate from the system clock. Once enabled, it counts oscillator cycles. If software does not send a restart strobe before the selected timeout, it raises a fixed-length reset pulse. After the pulse it starts counting again from zero. Software controls it through one 8-bit control register in the system clock domain. The register holds an enable bit, a self-clearing unlock bit and a 3-bit timeout select.

Enabling the watchdog is always accepted. Disabling it takes two writes. The first write sets the unlock bit, which opens a window of four system cycles. A second write, captured inside that window, may then clear the enable bit. A disable write outside the window is ignored. Software can therefore not switch the watchdog off by a single stray store.

The restart strobe crosses into the oscillator domain through a toggle handshake. A strobe that arrives while an earlier one is still in flight is folded into one follow-up transfer. The enable bit and the timeout select reach the oscillator domain through two-stage synchronizers.

Top module: `wdt_guard`

## Requirements
- R1: After reset the control readback is 0x00, the reset output is low, and the watchdog is disabled.
- R2: Control register layout: bit 0 is the enable bit, bit 1 is the unlock bit, and bits 4:2 are the timeout select. Bits 7:5 always read as zero, and values written to them are discarded.
- R3: A write with bit 0 = 1 always sets the enable bit. A write with bit 0 = 0 clears it only if the unlock bit was already set before that write. The timeout select is taken from every write.
- R4: A write with bit 1 = 1 sets the unlock bit, which then clears by itself after UNLOCK_CYCLES (4) system cycles. Disable writes captured on the 1st to 4th edge after the setting write are accepted, and on the 5th edge they are rejected. Writing 1 while the bit is set does not extend the window. Writing 0 to it has no effect.
- R5: While enabled, the watchdog fires after 2^(BASE_LOG2 + select) oscillator cycles of counting without a restart.
- R6: The reset pulse is high for exactly PULSE_LEN oscillator cycles. The count restarts from zero afterwards. With no restarts, consecutive pulse rises are 2^(BASE_LOG2+select) + PULSE_LEN oscillator cycles apart.
- R7: A one-cycle restart strobe in the system domain is delivered to the oscillator domain and clears the count. Restarts spaced closer than the timeout prevent any pulse, and a pulse follows once they stop.
- R8: While the watchdog is disabled, the count is held at zero and no reset pulse begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| ctrl_rd | output | 8 | Control register readback |
| kick | input | 1 | Restart strobe, one system cycle per restart |
| wdt_clk | input | 1 | Watchdog oscillator clock |
| wdt_rst_n | input | 1 | Oscillator-domain asynchronous reset, active low |
| wdt_reset_o | output | 1 | Reset pulse to the system, oscillator domain |

## Verification
Two events can meet on a single system clock edge: the unlock window closing by itself, and a write that tries to clear the enable bit. The bench places a disable write exactly on the fourth edge after the unlocking write, where it must be accepted and the readback must show the unlock bit dropping on that same edge. It places another disable write on the fifth edge, where the enable bit must survive. A third case rewrites the unlock bit in mid-window and then writes on the old closing edge. This case shows whether the rewrite wrongly extended the window.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  localparam int PS_W = 3;
  localparam int NUM_PS = 1 << PS_W;

  typedef struct packed {
    logic [2:0]      rsvd;
    logic [PS_W-1:0] sel;
    logic            unlock;
    logic            enable;
  } wdt_ctrl_t;

endpackage

// File: rtl/wdt_guard_sync.sv
module wdt_guard_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      ctrl_o,
  output logic            enable_o,
  output logic [PS_W-1:0] sel_o
);

  localparam int UW = $clog2(UNLOCK_CYCLES + 1);

  wdt_ctrl_t       wr_c;
  wdt_ctrl_t       rd_c;
  logic            enable_q;
  logic            unlock_q;
  logic [PS_W-1:0] sel_q;
  logic [UW-1:0]   ucnt_q;

  assign wr_c = wdt_ctrl_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      unlock_q <= 1'b0;
      sel_q    <= '0;
      ucnt_q   <= '0;
    end else begin
      // self-timed closing of the unlock window
      if (unlock_q) begin
        if (ucnt_q == '0) unlock_q <= 1'b0;
        else              ucnt_q   <= ucnt_q - 1'b1;
      end
      if (wr_en) begin
        sel_q <= wr_c.sel;
        if (wr_c.enable)   enable_q <= 1'b1;
        else if (unlock_q) enable_q <= 1'b0;
        if (wr_c.unlock && !unlock_q) begin
          unlock_q <= 1'b1;
          ucnt_q   <= UW'(UNLOCK_CYCLES - 1);
        end
      end
    end
  end

  always_comb begin
    rd_c        = '0;
    rd_c.enable = enable_q;
    rd_c.unlock = unlock_q;
    rd_c.sel    = sel_q;
  end

  assign ctrl_o   = rd_c;
  assign enable_o = enable_q;
  assign sel_o    = sel_q;

  // R3: the enable bit only ever falls while the window was open
  a_r3_disable_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enable_q) |-> $past(unlock_q));

  // R4: the window never stays open longer than UNLOCK_CYCLES cycles
  logic [UW:0] urun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        urun_q <= '0;
    else if (unlock_q) urun_q <= urun_q + 1'b1;
    else               urun_q <= '0;
  end
  a_r4_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    urun_q <= (UW+1)'(UNLOCK_CYCLES));

endmodule

// File: rtl/wdt_guard_kick.sv
module wdt_guard_kick (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic wdt_clk,
  input  logic wdt_rst_n,
  output logic restart_o
);

  logic req_q;
  logic pend_q;
  logic ack_s;
  logic req_s;
  logic ack_q;
  logic idle;

  // system side: toggle request, hold back further strobes until acknowledged
  assign idle = (req_q == ack_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (idle && (kick_i || pend_q)) begin
      req_q  <= ~req_q;
      pend_q <= 1'b0;
    end else if (kick_i) begin
      pend_q <= 1'b1;
    end
  end

  wdt_guard_sync #(.W(1), .STAGES(2)) u_req_sync (
    .clk(wdt_clk), .rst_n(wdt_rst_n), .d_i(req_q), .q_o(req_s)
  );

  always_ff @(posedge wdt_clk or negedge wdt_rst_n) begin
    if (!wdt_rst_n) ack_q <= 1'b0;
    else            ack_q <= req_s;
  end

  assign restart_o = req_s ^ ack_q;

  wdt_guard_sync #(.W(1), .STAGES(2)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ack_q), .q_o(ack_s)
  );

  // R7: each transfer yields a single-cycle restart in the oscillator domain
  a_r7_single_restart: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
    restart_o |=> !restart_o);

endmodule

// File: rtl/wdt_guard_core.sv
module wdt_guard_core
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int PULSE_LEN = 16
) (
  input  logic            wdt_clk,
  input  logic            wdt_rst_n,
  input  logic            en_i,
  input  logic [PS_W-1:0] sel_i,
  input  logic            restart_i,
  output logic            pulse_o
);

  localparam int CW = BASE_LOG2 + NUM_PS;
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] last_cnt [NUM_PS];
  logic [CW-1:0] cnt_q;
  logic          pulse_q;
  logic [PW-1:0] pcnt_q;

  for (genvar g = 0; g < NUM_PS; g++) begin : g_limit
    assign last_cnt[g] = CW'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
  end

  always_ff @(posedge wdt_clk or negedge wdt_rst_n) begin
    if (!wdt_rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      pcnt_q  <= '0;
    end else if (pulse_q) begin
      cnt_q <= '0;
      if (pcnt_q == PW'(PULSE_LEN - 1)) begin
        pulse_q <= 1'b0;
        pcnt_q  <= '0;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end else if (!en_i || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q >= last_cnt[sel_i]) begin
      pulse_q <= 1'b1;
      pcnt_q  <= '0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = pulse_q;

  // R6: pulse length is exactly PULSE_LEN oscillator cycles
  logic [PW:0] prun_q;
  always_ff @(posedge wdt_clk or negedge wdt_rst_n) begin
    if (!wdt_rst_n)   prun_q <= '0;
    else if (pulse_q) prun_q <= prun_q + 1'b1;
    else              prun_q <= '0;
  end
  a_r6_pulse_length: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
    $fell(pulse_q) |-> (prun_q == (PW+1)'(PULSE_LEN)));
  a_r6_pulse_not_long: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
    prun_q <= (PW+1)'(PULSE_LEN));

  // R8: a disabled watchdog starts no pulse
  a_r8_quiet_when_off: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
    (!en_i && !pulse_q) |=> !pulse_q);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2     = 14,
  parameter int PULSE_LEN     = 16,
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_rd,
  input  logic       kick,
  input  logic       wdt_clk,
  input  logic       wdt_rst_n,
  output logic       wdt_reset_o
);

  logic            enable_sys;
  logic [PS_W-1:0] sel_sys;
  logic [PS_W:0]   cfg_wdt;
  logic            restart_wdt;

  wdt_guard_ctrl #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_o(ctrl_rd), .enable_o(enable_sys), .sel_o(sel_sys)
  );

  wdt_guard_sync #(.W(PS_W + 1), .STAGES(2)) u_cfg_sync (
    .clk(wdt_clk), .rst_n(wdt_rst_n),
    .d_i({enable_sys, sel_sys}), .q_o(cfg_wdt)
  );

  wdt_guard_kick u_kick (
    .clk(clk), .rst_n(rst_n), .kick_i(kick),
    .wdt_clk(wdt_clk), .wdt_rst_n(wdt_rst_n), .restart_o(restart_wdt)
  );

  wdt_guard_core #(.BASE_LOG2(BASE_LOG2), .PULSE_LEN(PULSE_LEN)) u_core (
    .wdt_clk(wdt_clk), .wdt_rst_n(wdt_rst_n),
    .en_i(cfg_wdt[PS_W]), .sel_i(cfg_wdt[PS_W-1:0]),
    .restart_i(restart_wdt), .pulse_o(wdt_reset_o)
  );

  // R2: reserved bits never read back as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_rd[7:5] == 3'b000));

endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;

  localparam int BASE_LOG2 = 4;
  localparam int PULSE_LEN = 4;

  logic       clk = 1'b0;
  logic       wdt_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdt_rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       kick = 1'b0;
  logic [7:0] ctrl_rd;
  logic       wdt_reset_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;      // 50 MHz system clock
  always #50 wdt_clk = ~wdt_clk;

  wdt_guard #(.BASE_LOG2(BASE_LOG2), .PULSE_LEN(PULSE_LEN), .UNLOCK_CYCLES(4)) u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
    .kick(kick), .wdt_clk(wdt_clk), .wdt_rst_n(wdt_rst_n), .wdt_reset_o(wdt_reset_o)
  );

  // oscillator-domain monitor, sampled away from the active edge
  int  wcyc = 0;
  int  rises = 0;
  int  last_rise = -1;
  int  interval = 0;
  int  hrun = 0;
  int  width = 0;
  logic prev = 1'b0;
  always @(negedge wdt_clk) begin
    wcyc = wcyc + 1;
    if (wdt_reset_o && !prev) begin
      if (last_rise >= 0) interval = wcyc - last_rise;
      last_rise = wcyc;
      rises = rises + 1;
    end
    if (wdt_reset_o) hrun = hrun + 1;
    else if (prev) begin width = hrun; hrun = 0; end
    prev = wdt_reset_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(input int limit, output bit seen);
    int start = rises;
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge wdt_clk);
      if (rises != start) begin seen = 1'b1; break; end
    end
    @(negedge clk);
  endtask

  // {gap[3:0], write value, expected readback}
  localparam logic [19:0] VT [0:15] = '{
    20'h0_09_09, 20'h0_E9_09, 20'h0_00_01, 20'h0_03_03,
    20'h0_00_02, 20'h3_05_05, 20'h0_02_03, 20'h3_00_00,
    20'h0_03_03, 20'h4_00_01, 20'h0_03_03, 20'h1_02_02,
    20'h1_01_01, 20'h0_00_01, 20'h0_03_03, 20'h0_00_02
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; wdt_rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ctrl_rd == 8'h00, "R1 readback", ctrl_rd, 0);
    chk(wdt_reset_o == 1'b0, "R1 reset output", wdt_reset_o, 0);
    // R8 disabled watchdog stays quiet
    wait_rise(100, seen);
    chk(!seen, "R8 no pulse while disabled", seen, 0);

    // R2 R3 R4 register and unlock window table
    for (int i = 0; i < 16; i++) begin
      repeat (VT[i][19:16]) @(negedge clk);
      wr(VT[i][15:8]);
      chk(ctrl_rd == VT[i][7:0], $sformatf("R2 R3 R4 table step %0d", i),
          ctrl_rd, VT[i][7:0]);
    end

    // R5 R6 timeout with select 0: 16 + 4 cycles rise to rise
    wr(8'h01);
    wait_rise(200, seen);
    wait_rise(200, seen);
    chk(seen && interval == 20, "R5 interval select 0", interval, 20);
    wait_rise(200, seen);
    chk(width == PULSE_LEN, "R6 pulse width", width, PULSE_LEN);

    // R5 select 2: 64 + 4
    wr(8'h09);
    wait_rise(300, seen);
    wait_rise(300, seen);
    chk(seen && interval == 68, "R5 interval select 2", interval, 68);

    // R7 restarts keep it quiet, select 1 (32 cycles)
    wr(8'h05);
    wait_rise(300, seen);
    r0 = rises;
    for (int k = 0; k < 30; k++) begin
      repeat (15) @(negedge wdt_clk);
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
    end
    chk(rises == r0, "R7 restarts prevent timeout", rises - r0, 0);
    wait_rise(60, seen);
    chk(seen, "R7 pulse after restarts stop", seen, 1);

    // R8 disable via unlock sequence, then silence
    wr(8'h07);
    wr(8'h04);
    chk(ctrl_rd == 8'h06, "R3 disable accepted", ctrl_rd, 8'h06);
    repeat (20) @(negedge wdt_clk);
    r0 = rises;
    repeat (150) @(negedge wdt_clk);
    chk(rises == r0, "R8 no pulse after disable", rises - r0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule